// File: doc/BRIEF.md
# Host Port Request Line Controller

This block produces the single request line of a two-sided, double-buffered host port that links an external host processor to a signal-processing core. The host writes a small control word that holds three request-source enables, a mode bit that selects between interrupt and DMA meaning for the line, and a DMA direction bit. The block keeps four full flags: host transmit, core receive, core transmit and host receive. It moves a word across the port whenever the downstream register is empty. From the flags and the control word it drives an active-low request pin, and it returns the same state as a status bit when the control word is read back.

A self-clearing initialize command in the control word runs a short, fixed-length sequence. The sequence empties the buffers selected by the enables and then drops the command bit in hardware. There are three reset sources. The asynchronous hardware reset and the synchronous software reset clear everything. A synchronous host-port reset empties the buffers and preloads the request status from the enables.

Top module: `hostreq_ctrl`

## Requirements
- R1: The control word uses these bit positions: bit 0 receive enable, bit 1 transmit enable, bit 2 both-empty enable, bit 3 DMA mode, bit 4 DMA direction (1 = core to host, 0 = host to core), bit 6 initialize command, bit 7 read-only request status. Bit 5 reads 0. Bits 0 to 4 read back as they were written.
- R2: In interrupt mode, the receive enable requests service while the host receive register is full.
- R3: In interrupt mode, the transmit enable requests service while the host transmit register is empty.
- R4: In interrupt mode, the both-empty enable requests service only while the host transmit register and the core receive register are both empty.
- R5: In DMA mode, direction 1 requests on host receive full if the receive enable is set, and direction 0 requests on host transmit empty if the transmit enable is set. The both-empty enable has no effect in DMA mode.
- R6: The status bit is 1 exactly when hreq_n is 0. The status follows the flags and control word with a latency of one clock.
- R7: Hardware reset and software reset clear the control word, the initialize bit, all four full flags and the request status.
- R8: A host-port reset empties all four buffers and cancels a running initialize. Right after that edge, the status equals (transmit enable OR both-empty enable), whatever the mode.
- R9: Writing 1 to bit 6 starts the initialize sequence. Writing 0 to it, or writing 1 to it while a sequence is running, has no effect. The bit clears by itself INIT_CYC clock edges after the write, which is at most 3 edges.
- R10: When the initialize sequence finishes, the transmit enable empties the host transmit register, and the receive enable empties the host receive and core transmit registers. With both of these enables clear, all flags are left unchanged.
- R11: A full host transmit register moves into an empty core receive register in one clock. A full core transmit register moves into an empty host receive register in one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset |
| host_rst | input | 1 | Synchronous host-port reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write data |
| ctl_rdata | output | 8 | Control word read-back, including status |
| host_tx_wr | input | 1 | Host writes the transmit register |
| host_rx_rd | input | 1 | Host reads the receive register |
| core_htx_wr | input | 1 | Core writes its transmit register |
| core_hrx_rd | input | 1 | Core reads its receive register |
| hreq_n | output | 1 | Request pin, active low |
| tx_empty | output | 1 | Host transmit register empty |
| rx_full | output | 1 | Host receive register full |
| hrx_full | output | 1 | Core receive register full |
| htx_full | output | 1 | Core transmit register full |

## Verification
A corrupted full flag shows on the flag outputs at the next edge. One clock later it shows on hreq_n and on status bit 7, because the request register samples the flags. A stuck or early-clearing initialize sequence shows on bit 6 at the edge where it should still be set or should have dropped. A wrong flag action at the end of the sequence shows in the same cycle. A wrong mode or enable decode shows up only when the flags reach the distinguishing state, such as host transmit empty while the core receive register is full. The directed cases therefore build those states on purpose.

// File: rtl/hostreq_pkg.sv
package hostreq_pkg;
  localparam int CTL_W      = 8;
  localparam int B_EN_RX    = 0;
  localparam int B_EN_TX    = 1;
  localparam int B_EN_BOTH  = 2;
  localparam int B_DMA      = 3;
  localparam int B_DIR      = 4;
  localparam int B_INIT     = 6;
  localparam int B_STAT     = 7;

  typedef struct packed {
    logic dma_dir;
    logic dma_en;
    logic en_both;
    logic en_tx;
    logic en_rx;
  } ctl_t;

  typedef struct packed {
    logic tx_full;
    logic hrx_full;
    logic htx_full;
    logic rx_full;
  } flags_t;

  function automatic ctl_t ctl_from_bus(input logic [CTL_W-1:0] d);
    ctl_t c;
    c.en_rx   = d[B_EN_RX];
    c.en_tx   = d[B_EN_TX];
    c.en_both = d[B_EN_BOTH];
    c.dma_en  = d[B_DMA];
    c.dma_dir = d[B_DIR];
    return c;
  endfunction

  function automatic logic [CTL_W-1:0] ctl_to_bus(input ctl_t c, input logic busy,
                                                  input logic stat);
    logic [CTL_W-1:0] d;
    d            = '0;
    d[B_EN_RX]   = c.en_rx;
    d[B_EN_TX]   = c.en_tx;
    d[B_EN_BOTH] = c.en_both;
    d[B_DMA]     = c.dma_en;
    d[B_DIR]     = c.dma_dir;
    d[B_INIT]    = busy;
    d[B_STAT]    = stat;
    return d;
  endfunction

  // Request decision from control word and current buffer state.
  function automatic logic req_calc(input ctl_t c, input flags_t f);
    logic tx_mt;
    logic both_mt;
    logic r;
    tx_mt   = !f.tx_full;
    both_mt = tx_mt && !f.hrx_full;
    if (c.dma_en) begin
      r = c.dma_dir ? (c.en_rx && f.rx_full) : (c.en_tx && tx_mt);
    end else begin
      r = (c.en_rx && f.rx_full) || (c.en_tx && tx_mt) || (c.en_both && both_mt);
    end
    return r;
  endfunction
endpackage

// File: rtl/hostreq_ctl_reg.sv
module hostreq_ctl_reg
  import hostreq_pkg::*;
#(
  parameter int INIT_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             host_rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output ctl_t             ctl,
  output logic             init_busy,
  output logic             init_apply
);
  localparam int CNT_W = (INIT_CYC > 1) ? $clog2(INIT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(INIT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             start_req;
  logic             unused_bits;

  assign unused_bits = ^{ctl_wdata[5], ctl_wdata[B_STAT]};
  assign start_req   = ctl_we && ctl_wdata[B_INIT] && !init_busy && !host_rst;
  assign init_apply  = init_busy && (cnt_q == '0) && !host_rst && !sw_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl       <= '0;
      init_busy <= 1'b0;
      cnt_q     <= '0;
    end else if (sw_rst) begin
      ctl       <= '0;
      init_busy <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (ctl_we) ctl <= ctl_from_bus(ctl_wdata);
      if (host_rst) begin
        init_busy <= 1'b0;
        cnt_q     <= '0;
      end else if (init_busy) begin
        if (cnt_q == '0) init_busy <= 1'b0;
        else             cnt_q     <= cnt_q - 1'b1;
      end else if (start_req) begin
        init_busy <= 1'b1;
        cnt_q     <= CNT_LOAD;
      end
    end
  end
endmodule

// File: rtl/hostreq_flags.sv
module hostreq_flags
  import hostreq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sw_rst,
  input  logic   host_rst,
  input  logic   host_tx_wr,
  input  logic   host_rx_rd,
  input  logic   core_htx_wr,
  input  logic   core_hrx_rd,
  input  ctl_t   ctl,
  input  logic   init_apply,
  output flags_t flags,
  output logic   move_tx,
  output logic   move_rx
);
  flags_t nxt;

  assign move_tx = flags.tx_full && !flags.hrx_full;
  assign move_rx = flags.htx_full && !flags.rx_full;

  always_comb begin
    nxt.tx_full  = (flags.tx_full && !move_tx) || host_tx_wr;
    nxt.hrx_full = (flags.hrx_full && !core_hrx_rd) || move_tx;
    nxt.htx_full = (flags.htx_full && !move_rx) || core_htx_wr;
    nxt.rx_full  = (flags.rx_full && !host_rx_rd) || move_rx;
    if (init_apply && ctl.en_tx) nxt.tx_full = 1'b0;
    if (init_apply && ctl.en_rx) begin
      nxt.rx_full  = 1'b0;
      nxt.htx_full = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flags <= '0;
    else if (sw_rst || host_rst) flags <= '0;
    else                         flags <= nxt;
  end
endmodule

// File: rtl/hostreq_req_gen.sv
module hostreq_req_gen
  import hostreq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sw_rst,
  input  logic   host_rst,
  input  ctl_t   ctl,
  input  flags_t flags,
  output logic   req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        req_q <= 1'b0;
    else if (sw_rst)   req_q <= 1'b0;
    else if (host_rst) req_q <= ctl.en_tx || ctl.en_both;
    else               req_q <= req_calc(ctl, flags);
  end
endmodule

// File: rtl/hostreq_ctrl.sv
module hostreq_ctrl
  import hostreq_pkg::*;
#(
  parameter int INIT_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_rst,
  input  logic       host_rst,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       host_tx_wr,
  input  logic       host_rx_rd,
  input  logic       core_htx_wr,
  input  logic       core_hrx_rd,
  output logic       hreq_n,
  output logic       tx_empty,
  output logic       rx_full,
  output logic       hrx_full,
  output logic       htx_full
);
  ctl_t   ctl;
  flags_t flags;
  logic   init_busy;
  logic   init_apply;
  logic   move_tx;
  logic   move_rx;
  logic   req_q;

  hostreq_ctl_reg #(.INIT_CYC(INIT_CYC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .host_rst(host_rst),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl(ctl), .init_busy(init_busy), .init_apply(init_apply)
  );

  hostreq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .host_rst(host_rst),
    .host_tx_wr(host_tx_wr), .host_rx_rd(host_rx_rd),
    .core_htx_wr(core_htx_wr), .core_hrx_rd(core_hrx_rd),
    .ctl(ctl), .init_apply(init_apply),
    .flags(flags), .move_tx(move_tx), .move_rx(move_rx)
  );

  hostreq_req_gen u_req (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .host_rst(host_rst),
    .ctl(ctl), .flags(flags), .req_q(req_q)
  );

  assign ctl_rdata = ctl_to_bus(ctl, init_busy, req_q);
  assign hreq_n    = !req_q;
  assign tx_empty  = !flags.tx_full;
  assign rx_full   = flags.rx_full;
  assign hrx_full  = flags.hrx_full;
  assign htx_full  = flags.htx_full;
endmodule

// File: rtl/hostreq_ctrl_chk.sv
module hostreq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_rst,
  input logic       host_rst,
  input logic       ctl_we,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic       hreq_n,
  input logic       tx_empty,
  input logic       rx_full,
  input logic       hrx_full,
  input logic       htx_full,
  input logic       init_apply
);
  logic [3:0] init_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            init_run <= '0;
    else if (ctl_rdata[6]) init_run <= (init_run == 4'hf) ? init_run : init_run + 1'b1;
    else                   init_run <= '0;
  end

  // R7
  sw_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (ctl_rdata == 8'h00 && tx_empty && !rx_full && !hrx_full && !htx_full && hreq_n));

  // R8
  host_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rst && !sw_rst) |=> (ctl_rdata[7] == $past(ctl_rdata[1] | ctl_rdata[2])));

  // R9
  init_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[6] |-> (init_run < 4'd3));

  // R9
  init_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[6] && !ctl_rdata[6]) |=> !ctl_rdata[6]);

  // R11
  tx_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_empty && !hrx_full && !sw_rst && !host_rst) |=> hrx_full);

  // R11
  rx_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htx_full && !rx_full && !sw_rst && !host_rst && !init_apply) |=> rx_full);

  // R3
  tx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst && !host_rst && !ctl_rdata[3] && ctl_rdata[1] && tx_empty) |=> !hreq_n);
endmodule

bind hostreq_ctrl hostreq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .host_rst(host_rst),
  .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
  .hreq_n(hreq_n), .tx_empty(tx_empty), .rx_full(rx_full),
  .hrx_full(hrx_full), .htx_full(htx_full), .init_apply(init_apply)
);

// File: tb/hostreq_ctrl_tb.sv
module hostreq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_CYC   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_rst = 1'b0, host_rst = 1'b0, ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       host_tx_wr = 1'b0, host_rx_rd = 1'b0, core_htx_wr = 1'b0, core_hrx_rd = 1'b0;
  logic       hreq_n, tx_empty, rx_full, hrx_full, htx_full;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostreq_ctrl #(.INIT_CYC(INIT_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .host_rst(host_rst),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .host_tx_wr(host_tx_wr), .host_rx_rd(host_rx_rd),
    .core_htx_wr(core_htx_wr), .core_hrx_rd(core_hrx_rd),
    .hreq_n(hreq_n), .tx_empty(tx_empty), .rx_full(rx_full),
    .hrx_full(hrx_full), .htx_full(htx_full)
  );

  // Independent reference model of the requirements.
  logic m_rx, m_tx, m_both, m_dma, m_dir, m_init, m_req;
  int   m_cnt;
  logic m_txf, m_hrxf, m_htxf, m_rxf;

  function automatic logic ref_req(input logic rx_en, tx_en, both_en, dma, dir,
                                   input logic txf, hrxf, rxf);
    case ({dma, dir})
      2'b11:   return rx_en & rxf;
      2'b10:   return tx_en & ~txf;
      default: return (rx_en & rxf) | (tx_en & ~txf) | (both_en & ~(txf | hrxf));
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_rx, m_tx, m_both, m_dma, m_dir, m_init, m_req} <= '0;
      {m_txf, m_hrxf, m_htxf, m_rxf} <= '0;
      m_cnt <= 0;
    end else if (sw_rst) begin
      {m_rx, m_tx, m_both, m_dma, m_dir, m_init, m_req} <= '0;
      {m_txf, m_hrxf, m_htxf, m_rxf} <= '0;
      m_cnt <= 0;
    end else begin
      logic fin, mt, mr, ntx, nhrx, nhtx, nrx;
      if (ctl_we) {m_dir, m_dma, m_both, m_tx, m_rx} <= ctl_wdata[4:0];
      fin = m_init && (m_cnt == 0) && !host_rst;
      if (host_rst) m_init <= 1'b0;
      else if (m_init) begin
        if (m_cnt == 0) m_init <= 1'b0; else m_cnt <= m_cnt - 1;
      end else if (ctl_we && ctl_wdata[6]) begin
        m_init <= 1'b1; m_cnt <= INIT_CYC - 1;
      end
      mt = m_txf & ~m_hrxf;
      mr = m_htxf & ~m_rxf;
      ntx  = host_tx_wr | (m_txf & ~mt);
      nhrx = mt | (m_hrxf & ~core_hrx_rd);
      nhtx = core_htx_wr | (m_htxf & ~mr);
      nrx  = mr | (m_rxf & ~host_rx_rd);
      if (fin && m_tx) ntx = 1'b0;
      if (fin && m_rx) begin nrx = 1'b0; nhtx = 1'b0; end
      if (host_rst) {ntx, nhrx, nhtx, nrx} = '0;
      {m_txf, m_hrxf, m_htxf, m_rxf} <= {ntx, nhrx, nhtx, nrx};
      m_req <= host_rst ? (m_tx | m_both)
                        : ref_req(m_rx, m_tx, m_both, m_dma, m_dir, m_txf, m_hrxf, m_rxf);
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0; ctl_wdata = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: host_tx_wr = 1'b1;
      1: host_rx_rd = 1'b1;
      2: core_htx_wr = 1'b1;
      3: core_hrx_rd = 1'b1;
      4: host_rst = 1'b1;
      default: sw_rst = 1'b1;
    endcase
    @(negedge clk);
    {host_tx_wr, host_rx_rd, core_htx_wr, core_hrx_rd, host_rst, sw_rst} = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R7 reset state
    chk("R7 reset ctl", ctl_rdata, 8'h00);
    chk("R7 reset flags", {hreq_n, tx_empty, rx_full, hrx_full, htx_full}, 8'h18);

    // R1 readback of fields, bit 5 reads zero
    wr(8'h3f & 8'h31);
    chk("R1 readback", ctl_rdata & 8'h7f, 8'h11);
    wr(8'h00); idle(2);

    // R2 receive source
    wr(8'h01);
    pulse(2); idle(3);
    chk("R2 rx full request", {7'd0, hreq_n}, 8'h00);
    chk("R6 status mirrors pin", {7'd0, ctl_rdata[7]}, 8'h01);
    pulse(1); idle(2);
    chk("R2 rx empty no request", {7'd0, hreq_n}, 8'h01);

    // R3 transmit source
    wr(8'h02); idle(1);
    chk("R3 tx empty request", {7'd0, hreq_n}, 8'h00);
    pulse(0); idle(1); pulse(0); idle(2);
    chk("R3 tx full no request", {6'd0, hreq_n, tx_empty}, 8'h02);

    // R4 both-empty source
    wr(8'h04); idle(1);
    pulse(3); idle(2);
    chk("R4 tx empty hrx full", {6'd0, hreq_n, tx_empty}, 8'h03);
    pulse(3); idle(2);
    chk("R4 both empty request", {6'd0, hreq_n, hrx_full}, 8'h00);

    // R5 DMA mode
    wr(8'h0e); idle(1);
    chk("R5 dma host-to-core", {7'd0, hreq_n}, 8'h00);
    wr(8'h1c); idle(1);
    chk("R5 dma both enable ignored", {7'd0, hreq_n}, 8'h01);
    wr(8'h19); idle(1);
    chk("R5 dma core-to-host idle", {7'd0, hreq_n}, 8'h01);
    pulse(2); idle(3);
    chk("R5 dma core-to-host rx full", {7'd0, hreq_n}, 8'h00);
    pulse(1); idle(2);

    // R8 host-port reset
    wr(8'h02); pulse(0); idle(1); pulse(0); idle(2);
    pulse(4);
    chk("R8 host reset status", {6'd0, hreq_n, tx_empty, hrx_full}, 8'h02);
    wr(8'h0c);
    pulse(4);
    chk("R8 host reset dma both", {7'd0, ctl_rdata[7]}, 8'h01);
    idle(1);
    chk("R5 dma both ignored after", {7'd0, hreq_n}, 8'h01);

    // R9 R10 init sequence
    wr(8'h03);
    pulse(2); idle(2); pulse(2);
    pulse(0); idle(2); pulse(0); idle(1);
    chk("R10 preload", {4'd0, tx_empty, rx_full, hrx_full, htx_full}, 8'h07);
    wr(8'h43);
    chk("R9 init set", {7'd0, ctl_rdata[6]}, 8'h01);
    wr(8'h03);
    chk("R9 write zero ignored", {7'd0, ctl_rdata[6]}, 8'h01);
    idle(1);
    chk("R9 init self cleared", {7'd0, ctl_rdata[6]}, 8'h00);
    chk("R10 init flags", {4'd0, tx_empty, rx_full, hrx_full, htx_full}, 8'h0a);
    wr(8'h04); pulse(0); idle(1);
    wr(8'h44); idle(INIT_CYC);
    chk("R10 init no change", {4'd0, ctl_rdata[6], tx_empty, hrx_full, 1'b0}, 8'h02);

    // R7 software reset
    pulse(5);
    chk("R7 sw reset", {ctl_rdata[6:0], hreq_n}, 8'h01);
    chk("R7 sw reset flags", {4'd0, tx_empty, rx_full, hrx_full, htx_full}, 8'h08);

    // Random phase against the model
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3000; i++) begin
      ctl_we      = ($urandom_range(7) == 0);
      ctl_wdata   = 8'($urandom);
      host_tx_wr  = $urandom_range(1);
      host_rx_rd  = $urandom_range(1);
      core_htx_wr = $urandom_range(1);
      core_hrx_rd = $urandom_range(1);
      host_rst    = ($urandom_range(63) == 0);
      sw_rst      = ($urandom_range(127) == 0);
      @(negedge clk);
      chk("R1 ctl readback", ctl_rdata,
          {m_req, m_init, 1'b0, m_dir, m_dma, m_both, m_tx, m_rx});
      chk("R6 pin", {7'd0, hreq_n}, {7'd0, ~m_req});
      chk("R11 flags", {4'd0, tx_empty, rx_full, hrx_full, htx_full},
          {4'd0, ~m_txf, m_rxf, m_hrxf, m_htxf});
    end
    {ctl_we, host_tx_wr, host_rx_rd, core_htx_wr, core_hrx_rd, host_rst, sw_rst} = '0;
    idle(2);
    finish_run();
  end
endmodule